// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block generates the scanline timing for a raster display. A horizontal counter advances on every pixel-clock enable and a vertical counter advances once per line. Both wrap at programmable totals. The horizontal phase is not built from widths. Each phase has its own absolute compare register. When the horizontal count equals one of these values, the controller latches into that phase and stays there until another compare fires. When several compares match on the same pixel, a fixed priority decides which phase wins.

The phase drives several outputs. The hsync output follows the sync phase. Pixel requests are raised during the image phase, and a programmable solid colour is driven during the two border phases. Windowed horizontal and vertical interrupts set write-one-to-clear status bits, and each can be masked. A pending framebuffer choice is applied only at the end of a frame. Software reaches the block through a 32-bit word-addressed register port, which can also read back both beam counters. Fetching pixels is left to a neighbouring block, which is told only when image pixels are wanted.

Top module: `disp_tgen`

## Requirements
- R1: After a synchronous reset, every output is 0 and the control register (word 0) reads 0.
- R2: While enabled, the horizontal count (read at word 14) steps once per pixel enable from 0 up to the total in word 2 (bits 11:0) inclusive, then returns to 0. Read data appears one clock after the address.
- R3: The vertical count (read at word 15) steps when the horizontal count wraps. It returns to 0 after reaching the total in word 3.
- R4: The phase latches on equality of the horizontal count with the following compares: sync (word 4), back porch (word 5), left border (word 6), image start (word 7 bits 11:0), right border (word 7 bits 27:16) and front porch (word 8). The new phase is visible after the enable on which the match occurs. hsync is high in the sync phase and pix_req is high in the image phase. pix_rgb carries the border colour in both border phases and is 0 otherwise. Front porch is the phase after reset or disable.
- R5: When several compares match on one pixel, the winner follows this order: sync, back porch, left border, image, right border, front porch.
- R6: Word 13 holds the border colour. Only bits 23:0 are stored, and bits 31:24 are ignored.
- R7: The horizontal interrupt window opens when the horizontal count equals word 9 bits 11:0 and closes when it equals word 9 bits 27:16. Opening it sets status bit 16 of word 1.
- R8: The vertical interrupt window uses word 10 against the vertical count and is evaluated only on the pixel where the horizontal count is 0. Opening it sets status bit 17. vsync uses a window of the same kind, set by word 11.
- R9: irq_h is high only while its window is open, status bit 16 is set and mask bit 8 of word 0 is 0. irq_v works the same way with bit 17 and mask bit 9.
- R10: Writing 1 to bit 16 or 17 of word 1 clears that status bit. Writing 0 leaves it unchanged.
- R11: Bit 0 of word 0 enables the block. While it is 0, both counters are held at 0, the phase is front porch and both windows are closed.
- R12: Bit 0 of word 1 selects the next framebuffer. It reaches fb_sel, which is also readable as bit 4 of word 1, only on the last pixel of a frame.
- R13: Bit 0 of word 12 forces hsync low and bit 8 forces vsync low. The timing underneath keeps running.
- R14: While pix_en is low, the counters and the phase hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| pix_req | output | 1 | Image pixels are requested |
| pix_rgb | output | 24 | Border colour during border phases, else 0 |
| irq_h | output | 1 | Horizontal interrupt |
| irq_v | output | 1 | Vertical interrupt |
| fb_sel | output | 1 | Framebuffer currently shown |

## Verification
One full frame with a short line is walked pixel by pixel, and every phase boundary is checked on the pixel right after its compare. This shows whether each compare fires on equality with the count before it advances or one pixel early or late. A second run programs the sync and back-porch compares to the same value, which separates a correct priority from a reversed one. Writes placed in the middle of the frame are used for two checks. They toggle the masks and the sync-disable bits while the windows are open, and they separate output gating from corruption of the underlying timing. A frame-end check shows that the framebuffer select does not follow its register early.

// File: rtl/disp_tgen_pkg.sv
package disp_tgen_pkg;
  typedef enum logic [2:0] {
    PH_FRONT = 3'd0,
    PH_HSYNC = 3'd1,
    PH_BACK  = 3'd2,
    PH_LBORD = 3'd3,
    PH_IMAGE = 3'd4,
    PH_RBORD = 3'd5
  } phase_e;

  typedef logic [3:0] raddr_t;

  localparam raddr_t A_CTRL   = 4'd0;
  localparam raddr_t A_STAT   = 4'd1;
  localparam raddr_t A_HTOT   = 4'd2;
  localparam raddr_t A_VTOT   = 4'd3;
  localparam raddr_t A_HSYNC  = 4'd4;
  localparam raddr_t A_HBACK  = 4'd5;
  localparam raddr_t A_HLBORD = 4'd6;
  localparam raddr_t A_HIMG   = 4'd7;
  localparam raddr_t A_HFRONT = 4'd8;
  localparam raddr_t A_HIRQ   = 4'd9;
  localparam raddr_t A_VIRQ   = 4'd10;
  localparam raddr_t A_VSYNC  = 4'd11;
  localparam raddr_t A_SYNCOFF = 4'd12;
  localparam raddr_t A_BORDER = 4'd13;
  localparam raddr_t A_HCOUNT = 4'd14;
  localparam raddr_t A_VCOUNT = 4'd15;

  localparam int NTIM = int'(A_VSYNC) - int'(A_HTOT) + 1;
endpackage

// File: rtl/disp_tgen_regs.sv
module disp_tgen_regs
  import disp_tgen_pkg::*;
#(
  parameter int CW   = 12,
  parameter int COLW = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wen,
  input  raddr_t          addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [CW-1:0]   hcnt,
  input  logic [CW-1:0]   vcnt,
  input  logic            hset,
  input  logic            vset,
  input  logic            frame_end,
  output logic            en,
  output logic            hmask,
  output logic            vmask,
  output logic            hs_off,
  output logic            vs_off,
  output logic [CW-1:0]   htotal,
  output logic [CW-1:0]   vtotal,
  output logic [CW-1:0]   hsync_at,
  output logic [CW-1:0]   hback_at,
  output logic [CW-1:0]   hlbord_at,
  output logic [CW-1:0]   himg_lo,
  output logic [CW-1:0]   himg_hi,
  output logic [CW-1:0]   hfront_at,
  output logic [CW-1:0]   hirq_lo,
  output logic [CW-1:0]   hirq_hi,
  output logic [CW-1:0]   virq_lo,
  output logic [CW-1:0]   virq_hi,
  output logic [CW-1:0]   vs_lo,
  output logic [CW-1:0]   vs_hi,
  output logic [COLW-1:0] border,
  output logic            hstat,
  output logic            vstat,
  output logic            fb_cur
);
  localparam int PADW = 16 - CW;
  localparam int CPAD = 32 - CW;
  localparam int BPAD = 32 - COLW;

  logic [CW-1:0] lo_q [NTIM];
  logic [CW-1:0] hi_q [NTIM];
  logic          fb_next;

  // one low/high field pair per timing word
  for (genvar i = 0; i < NTIM; i++) begin : g_tim
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end else if (wen && addr == raddr_t'(i + int'(A_HTOT))) begin
        lo_q[i] <= wdata[CW-1:0];
        hi_q[i] <= wdata[16+CW-1:16];
      end
    end
  end

  assign htotal    = lo_q[A_HTOT   - A_HTOT];
  assign vtotal    = lo_q[A_VTOT   - A_HTOT];
  assign hsync_at  = lo_q[A_HSYNC  - A_HTOT];
  assign hback_at  = lo_q[A_HBACK  - A_HTOT];
  assign hlbord_at = lo_q[A_HLBORD - A_HTOT];
  assign himg_lo   = lo_q[A_HIMG   - A_HTOT];
  assign himg_hi   = hi_q[A_HIMG   - A_HTOT];
  assign hfront_at = lo_q[A_HFRONT - A_HTOT];
  assign hirq_lo   = lo_q[A_HIRQ   - A_HTOT];
  assign hirq_hi   = hi_q[A_HIRQ   - A_HTOT];
  assign virq_lo   = lo_q[A_VIRQ   - A_HTOT];
  assign virq_hi   = hi_q[A_VIRQ   - A_HTOT];
  assign vs_lo     = lo_q[A_VSYNC  - A_HTOT];
  assign vs_hi     = hi_q[A_VSYNC  - A_HTOT];

  logic clr_h, clr_v;
  assign clr_h = wen && addr == A_STAT && wdata[16];
  assign clr_v = wen && addr == A_STAT && wdata[17];

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; hmask <= 1'b0; vmask <= 1'b0;
      hs_off <= 1'b0; vs_off <= 1'b0;
      border <= '0; fb_next <= 1'b0; fb_cur <= 1'b0;
      hstat <= 1'b0; vstat <= 1'b0;
    end else begin
      if (wen && addr == A_CTRL) begin
        en <= wdata[0]; hmask <= wdata[8]; vmask <= wdata[9];
      end
      if (wen && addr == A_SYNCOFF) begin
        hs_off <= wdata[0]; vs_off <= wdata[8];
      end
      if (wen && addr == A_BORDER) border <= wdata[COLW-1:0];
      if (wen && addr == A_STAT) fb_next <= wdata[0];
      if (frame_end) fb_cur <= fb_next;
      hstat <= hset | (hstat & ~clr_h);
      vstat <= vset | (vstat & ~clr_v);
    end
  end

  raddr_t tidx;
  assign tidx = addr - A_HTOT;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_CTRL:    rdata <= {22'd0, vmask, hmask, 7'd0, en};
        A_STAT:    rdata <= {14'd0, vstat, hstat, 11'd0, fb_cur, 3'd0, fb_next};
        A_SYNCOFF: rdata <= {23'd0, vs_off, 7'd0, hs_off};
        A_BORDER:  rdata <= {{BPAD{1'b0}}, border};
        A_HCOUNT:  rdata <= {{CPAD{1'b0}}, hcnt};
        A_VCOUNT:  rdata <= {{CPAD{1'b0}}, vcnt};
        default:   rdata <= {{PADW{1'b0}}, hi_q[tidx], {PADW{1'b0}}, lo_q[tidx]};
      endcase
    end
  end

  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wen && addr == A_STAT && wdata[16] && !hset) |=> !hstat);
  // R7
  hstat_set_chk: assert property (@(posedge clk) disable iff (rst)
    hset |=> hstat);
  // R12
  fb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(fb_cur));
endmodule

// File: rtl/disp_tgen_hphase.sv
module disp_tgen_hphase
  import disp_tgen_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          pix_en,
  input  logic [CW-1:0] htotal,
  input  logic [CW-1:0] vtotal,
  input  logic [CW-1:0] hsync_at,
  input  logic [CW-1:0] hback_at,
  input  logic [CW-1:0] hlbord_at,
  input  logic [CW-1:0] himg_lo,
  input  logic [CW-1:0] himg_hi,
  input  logic [CW-1:0] hfront_at,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt,
  output phase_e        phase,
  output logic          tick,
  output logic          line0,
  output logic          frame_end
);
  localparam int NPH = 6;

  // index 0 is the highest priority
  function automatic phase_e ph_of(input int i);
    case (i)
      0:       return PH_HSYNC;
      1:       return PH_BACK;
      2:       return PH_LBORD;
      3:       return PH_IMAGE;
      4:       return PH_RBORD;
      default: return PH_FRONT;
    endcase
  endfunction

  logic [CW-1:0]  at_v [NPH];
  logic [NPH-1:0] hit;
  phase_e         nxt;

  assign at_v[0] = hsync_at;
  assign at_v[1] = hback_at;
  assign at_v[2] = hlbord_at;
  assign at_v[3] = himg_lo;
  assign at_v[4] = himg_hi;
  assign at_v[5] = hfront_at;

  for (genvar i = 0; i < NPH; i++) begin : g_cmp
    assign hit[i] = (hcnt == at_v[i]);
  end

  always_comb begin
    nxt = phase;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (hit[i]) nxt = ph_of(i);
    end
  end

  logic hwrap;
  assign tick      = en && pix_en;
  assign hwrap     = (hcnt == htotal);
  assign line0     = tick && (hcnt == '0);
  assign frame_end = tick && hwrap && (vcnt == vtotal);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hcnt  <= '0;
      vcnt  <= '0;
      phase <= PH_FRONT;
    end else if (tick) begin
      phase <= nxt;
      if (hwrap) begin
        hcnt <= '0;
        vcnt <= (vcnt == vtotal) ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  // R2
  hwrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && hcnt == htotal) |=> (hcnt == '0));
  // R14
  pixen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !pix_en) |=> ($stable(hcnt) && $stable(vcnt) && $stable(phase)));
  // R11
  off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (hcnt == '0 && vcnt == '0));
  // R5
  sync_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && hcnt == hsync_at) |=> (phase == PH_HSYNC));
endmodule

// File: rtl/disp_tgen_win.sv
module disp_tgen_win #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          gate,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic          win,
  output logic          hit
);
  assign hit = gate && (cnt == lo);

  always_ff @(posedge clk) begin
    if (rst || clr)                win <= 1'b0;
    else if (hit)                  win <= 1'b1;
    else if (gate && cnt == hi)    win <= 1'b0;
  end

  // R7, R8
  win_open_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !clr) |=> win);
  // R11
  win_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !win);
endmodule

// File: rtl/disp_tgen.sv
module disp_tgen
  import disp_tgen_pkg::*;
#(
  parameter int CW   = 12,
  parameter int COLW = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pix_en,
  input  logic            reg_wen,
  input  logic [3:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            hsync,
  output logic            vsync,
  output logic            pix_req,
  output logic [COLW-1:0] pix_rgb,
  output logic            irq_h,
  output logic            irq_v,
  output logic            fb_sel
);
  logic en, hmask, vmask, hs_off, vs_off, hstat, vstat, fb_cur;
  logic [CW-1:0] htotal, vtotal, hsync_at, hback_at, hlbord_at, himg_lo, himg_hi;
  logic [CW-1:0] hfront_at, hirq_lo, hirq_hi, virq_lo, virq_hi, vs_lo, vs_hi;
  logic [CW-1:0] hcnt, vcnt;
  logic [COLW-1:0] border;
  logic tick, line0, frame_end;
  logic hwin, hset, vwin, vset, swin, sset;
  phase_e phase;

  disp_tgen_regs #(.CW(CW), .COLW(COLW)) u_regs (
    .clk(clk), .rst(rst), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .hcnt(hcnt), .vcnt(vcnt), .hset(hset), .vset(vset),
    .frame_end(frame_end), .en(en), .hmask(hmask), .vmask(vmask),
    .hs_off(hs_off), .vs_off(vs_off), .htotal(htotal), .vtotal(vtotal),
    .hsync_at(hsync_at), .hback_at(hback_at), .hlbord_at(hlbord_at),
    .himg_lo(himg_lo), .himg_hi(himg_hi), .hfront_at(hfront_at),
    .hirq_lo(hirq_lo), .hirq_hi(hirq_hi), .virq_lo(virq_lo), .virq_hi(virq_hi),
    .vs_lo(vs_lo), .vs_hi(vs_hi), .border(border), .hstat(hstat),
    .vstat(vstat), .fb_cur(fb_cur)
  );

  disp_tgen_hphase #(.CW(CW)) u_hphase (
    .clk(clk), .rst(rst), .en(en), .pix_en(pix_en), .htotal(htotal),
    .vtotal(vtotal), .hsync_at(hsync_at), .hback_at(hback_at),
    .hlbord_at(hlbord_at), .himg_lo(himg_lo), .himg_hi(himg_hi),
    .hfront_at(hfront_at), .hcnt(hcnt), .vcnt(vcnt), .phase(phase),
    .tick(tick), .line0(line0), .frame_end(frame_end)
  );

  disp_tgen_win #(.CW(CW)) u_hirq (
    .clk(clk), .rst(rst), .clr(!en), .gate(tick), .cnt(hcnt),
    .lo(hirq_lo), .hi(hirq_hi), .win(hwin), .hit(hset)
  );

  disp_tgen_win #(.CW(CW)) u_virq (
    .clk(clk), .rst(rst), .clr(!en), .gate(line0), .cnt(vcnt),
    .lo(virq_lo), .hi(virq_hi), .win(vwin), .hit(vset)
  );

  disp_tgen_win #(.CW(CW)) u_vsync (
    .clk(clk), .rst(rst), .clr(!en), .gate(line0), .cnt(vcnt),
    .lo(vs_lo), .hi(vs_hi), .win(swin), .hit(sset)
  );

  logic in_border;
  assign in_border = (phase == PH_LBORD) || (phase == PH_RBORD);

  assign hsync   = (phase == PH_HSYNC) && !hs_off;
  assign vsync   = swin && !vs_off;
  assign pix_req = (phase == PH_IMAGE);
  assign pix_rgb = in_border ? border : '0;
  assign irq_h   = hwin && hstat && !hmask;
  assign irq_v   = vwin && vstat && !vmask;
  assign fb_sel  = fb_cur;

  // R8
  vsync_open_chk: assert property (@(posedge clk) disable iff (rst)
    (sset && en) |=> (vsync || vs_off));
endmodule

// File: tb/disp_tgen_tb.sv
module disp_tgen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b1;
  logic reg_wen = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic hsync, vsync, pix_req, irq_h, irq_v, fb_sel;
  logic [23:0] pix_rgb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  disp_tgen u_dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync(hsync), .vsync(vsync), .pix_req(pix_req), .pix_rgb(pix_rgb),
    .irq_h(irq_h), .irq_v(irq_v), .fb_sel(fb_sel)
  );

  localparam logic [23:0] COL = 24'h123456;

  typedef struct packed {
    logic [7:0] k;
    logic       hs;
    logic       pr;
    logic       brd;
    logic       ih;
    logic       iv;
    logic [7:0] rd;
  } vec_t;

  // pixel k after enable: phase from count k-1 (line of 20)
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'd1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0},
    '{8'd2,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},
    '{8'd3,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},
    '{8'd5,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd4},
    '{8'd7,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},
    '{8'd11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd10},
    '{8'd13, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd12},
    '{8'd14, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd13},
    '{8'd15, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd14},
    '{8'd17, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd16},
    '{8'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd19},
    '{8'd21, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    reg_addr = 4'd0;
    @(posedge clk); #1;
    chk("R1 ctrl", reg_rdata, 32'd0);
    chk("R1 outs", {hsync, vsync, pix_req, irq_h, irq_v, fb_sel}, 32'd0);
    chk("R1 rgb", {8'd0, pix_rgb}, 32'd0);

    wr(4'd2, 32'd19);
    wr(4'd3, 32'd3);
    wr(4'd4, 32'd0);
    wr(4'd5, 32'd2);
    wr(4'd6, 32'd4);
    wr(4'd7, 32'h000E_0006);
    wr(4'd8, 32'd16);
    wr(4'd9, 32'h000C_000A);
    wr(4'd10, 32'h0002_0001);
    wr(4'd11, 32'h0000_0003);
    wr(4'd13, 32'hAB12_3456);
    wr(4'd1, 32'h0000_0001);
    wr(4'd0, 32'h0000_0001);
    reg_addr = 4'd14;

    for (int k = 1; k <= 81; k++) begin
      @(posedge clk); #1;
      for (int j = 0; j < NV; j++) begin
        if (int'(VEC[j].k) == k) begin
          chk("R4 hsync", {31'd0, hsync}, {31'd0, VEC[j].hs});
          chk("R4 pix_req", {31'd0, pix_req}, {31'd0, VEC[j].pr});
          chk("R4 R6 rgb", {8'd0, pix_rgb}, VEC[j].brd ? {8'd0, COL} : 32'd0);
          chk("R7 irq_h", {31'd0, irq_h}, {31'd0, VEC[j].ih});
          chk("R8 irq_v", {31'd0, irq_v}, {31'd0, VEC[j].iv});
          chk("R2 hcount", reg_rdata, {24'd0, VEC[j].rd});
        end
      end
      if (k == 30) begin reg_wen = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h201; end
      if (k == 31) begin reg_wen = 1'b0; chk("R9 vmask", {31'd0, irq_v}, 32'd0); end
      if (k == 32) begin reg_wen = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h001; end
      if (k == 33) begin reg_wen = 1'b0; chk("R9 unmask", {31'd0, irq_v}, 32'd1); end
      if (k == 40) chk("R8 vwin open", {31'd0, irq_v}, 32'd1);
      if (k == 41) chk("R8 vwin close", {31'd0, irq_v}, 32'd0);
      if (k == 50) reg_addr = 4'd15;
      if (k == 51) begin chk("R3 vcount", reg_rdata, 32'd2); reg_addr = 4'd14; end
      if (k == 60) begin reg_wen = 1'b1; reg_addr = 4'd12; reg_wdata = 32'h101; end
      if (k == 61) begin
        reg_wen = 1'b0; reg_addr = 4'd14;
        chk("R13 hsync off", {31'd0, hsync}, 32'd0);
        chk("R13 vsync off", {31'd0, vsync}, 32'd0);
      end
      if (k == 62) begin reg_wen = 1'b1; reg_addr = 4'd12; reg_wdata = 32'h000; end
      if (k == 63) begin
        reg_wen = 1'b0; reg_addr = 4'd14;
        chk("R13 vsync back", {31'd0, vsync}, 32'd1);
      end
      if (k == 79) chk("R12 fb before", {31'd0, fb_sel}, 32'd0);
      if (k == 80) chk("R12 fb swap", {31'd0, fb_sel}, 32'd1);
      if (k == 81) chk("R8 vsync close", {31'd0, vsync}, 32'd0);
    end

    pix_en = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk("R14 hold a", reg_rdata, 32'd1);
    repeat (3) @(posedge clk); #1;
    chk("R14 hold b", reg_rdata, 32'd1);
    pix_en = 1'b1;

    wr(4'd0, 32'd0);
    repeat (3) @(posedge clk); #1;
    chk("R11 hcount", reg_rdata, 32'd0);
    chk("R11 outs", {hsync, vsync, pix_req, irq_h, irq_v}, 32'd0);

    reg_addr = 4'd1;
    @(posedge clk); #1;
    chk("R10 stat set", reg_rdata, 32'h0003_0011);
    wr(4'd1, 32'h0001_0001);
    @(posedge clk); #1;
    chk("R10 w1c", reg_rdata, 32'h0002_0011);

    reg_addr = 4'd13;
    @(posedge clk); #1;
    chk("R6 border rb", reg_rdata, 32'h0012_3456);

    wr(4'd5, 32'd0);
    wr(4'd0, 32'd1);
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); #1;
      if (k == 4) chk("R5 sync wins", {31'd0, hsync}, 32'd1);
      if (k == 5) begin
        chk("R5 lbord", {31'd0, hsync}, 32'd0);
        chk("R5 rgb", {8'd0, pix_rgb}, {8'd0, COL});
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule